// File: doc/BRIEF.md
# Destination Address Receive Filter

This block sits in an Ethernet receive path and decides whether the frame now arriving should be kept. The receive path streams the destination address to it one byte per clock, first byte first, and marks the end of every frame with a one-cycle pulse. The filter collects the six address bytes. While the bytes go by it folds them into a reflected CRC-32. In the cycle after the sixth byte it registers an accept decision and a flag that tells the receive path whether to drop the 4-byte FCS.

The decision checks the following, in priority order:
- The receive enable gates everything.
- Promiscuous mode takes every frame.
- The all-ones broadcast address is always taken.
- A group address (bit 0 of the first byte set) is taken in all-multicast mode, or when its hash bucket is set in a 64-bit table.
- An individual address is taken only on an exact 48-bit match with the station address.

The station address arrives as three 16-bit words. The hash table arrives as four 16-bit words. Configuration is sampled on the clock edge that takes the sixth byte.

The control state machine has three states:
- `ST_IDLE`: waiting for the first byte of a frame. The previous decision stays on the outputs.
- `ST_ADDR`: collecting address bytes two to six.
- `ST_DONE`: the decision is out; further bytes are ignored.

Its transitions are:
- `T_START`: IDLE to ADDR on the first byte. This clears the old decision.
- `T_NEXT`: ADDR to ADDR on bytes two to five.
- `T_DECIDE`: ADDR to DONE on the sixth byte. This registers the decision.
- `T_ABORT`: ADDR to IDLE on a frame end before six bytes have arrived. No decision is made.
- `T_END`: DONE to IDLE on frame end.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept` and `strip_fcs` are all 0.
- R2: When the sixth byte of a frame is taken at a clock edge, `dec_valid` is 1 after that edge. `accept` and `strip_fcs` then hold their values until the first byte of the next frame is taken, and that byte clears all three. Bytes beyond the sixth and a frame-end pulse do not change them. Configuration changes after the sixth byte do not change them either.
- R3: With `rx_en` = 0 at the decision edge, `accept` is 0 whatever the address and the other controls.
- R4: With `rx_en` = 1 and `promisc` = 1, every frame is accepted.
- R5: The destination FF:FF:FF:FF:FF:FF is accepted whenever `rx_en` = 1.
- R6: An individual address (bit 0 of byte 0 clear) is accepted only when all six bytes equal the station address. Byte 2k is bits [7:0] of `sta_wk` and byte 2k+1 is bits [15:8].
- R7: A group address (bit 0 of byte 0 set) is accepted when `allmulti` = 1, regardless of the hash table.
- R8: Otherwise, a group address is accepted when its table bit is 1. The table bit is found as follows:
  - c is the reflected CRC-32 of the six bytes: polynomial 0xEDB88320, initial value 0xFFFFFFFF, each byte fed LSB first, no final inversion.
  - idx is c[5:0] reversed, so idx[5] = c[0].
  - idx[5:3] picks table byte j. Byte 2k is `hash_wk[7:0]` and byte 2k+1 is `hash_wk[15:8]`.
  - idx[2:0] picks the bit within byte j.
- R9: `strip_fcs` equals `strip_crc` as sampled at the decision edge.
- R10: A frame-end pulse before the sixth byte abandons the frame. No decision appears (`dec_valid` stays 0), and the next byte starts a new frame at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates all acceptance |
| promisc | input | 1 | Accept every frame |
| allmulti | input | 1 | Accept every group-addressed frame |
| strip_crc | input | 1 | Request FCS removal for this frame |
| sta_w0 | input | 16 | Station address bytes 1:0 (byte 0 low) |
| sta_w1 | input | 16 | Station address bytes 3:2 |
| sta_w2 | input | 16 | Station address bytes 5:4 |
| hash_w0 | input | 16 | Hash table bytes 1:0 |
| hash_w1 | input | 16 | Hash table bytes 3:2 |
| hash_w2 | input | 16 | Hash table bytes 5:4 |
| hash_w3 | input | 16 | Hash table bytes 7:6 |
| rx_byte_valid | input | 1 | A destination address byte is present |
| rx_byte | input | 8 | Address byte |
| rx_frame_end | input | 1 | One-cycle end-of-frame pulse |
| dec_valid | output | 1 | Decision is valid |
| accept | output | 1 | Keep the frame |
| strip_fcs | output | 1 | Drop the 4-byte FCS of this frame |

## Verification
The main decision path is driven with several kinds of address:
- The exact station address, and the station address with one random bit flipped. These separate a full 48-bit compare from a partial one.
- Broadcast addresses, which must pass with an empty table.
- Random group addresses against a table holding only their own bucket, and against a table holding every bucket except theirs. These pin down the CRC, the bit reversal and the byte-major table layout together.
- Random addresses under random settings of the four control bits. These check the priority order among enable, promiscuous, all-multicast, hash and station match.

Short frames, trailing bytes and control changes during the hold period show that the decision window opens and closes on the right bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int WORD_W     = 16;
    localparam int HASH_BITS  = 6;
    localparam int TABLE_BITS = 1 << HASH_BITS;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DONE
    } flt_state_e;
endpackage

// File: rtl/rxf_crc_serial.sv
module rxf_crc_serial
    import rxf_pkg::*;
#(
    parameter int               DW    = BYTE_W,
    parameter int               OUT_W = HASH_BITS,
    parameter logic [CRC_W-1:0] POLY  = CRC_POLY,
    parameter logic [CRC_W-1:0] SEED  = CRC_INIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DW-1:0]    din,
    output logic [OUT_W-1:0] crc_low
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_d;

    // One byte folded per clock, LSB first, reflected polynomial.
    always_comb begin
        crc_d = restart ? SEED : crc_q;
        for (int i = 0; i < DW; i++) begin
            if (crc_d[0] ^ din[i])
                crc_d = (crc_d >> 1) ^ POLY;
            else
                crc_d = crc_d >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= SEED;
        else if (step)
            crc_q <= crc_d;
    end

    assign crc_low = crc_d[OUT_W-1:0];
endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
    import rxf_pkg::*;
#(
    parameter int IDX_W = HASH_BITS,
    localparam int TBL_W = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] crc_low,
    input  logic [TBL_W-1:0] table_bits,
    output logic             hit
);
    logic [IDX_W-1:0] idx;

    // Bucket index is the CRC low bits in reversed order.
    for (genvar g = 0; g < IDX_W; g++) begin : g_rev
        assign idx[g] = crc_low[IDX_W-1-g];
    end

    // Byte-major table: idx[5:3] byte, idx[2:0] bit -> flat position idx.
    assign hit = table_bits[idx];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    localparam int AW    = NBYTES * BYTE_W,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              frame_end,
    input  logic              rx_en,
    input  logic              promisc,
    input  logic              allmulti,
    input  logic              strip_cfg,
    input  logic [AW-1:0]     station,
    input  logic              hash_hit,
    output logic              crc_restart,
    output logic              crc_step,
    output logic              dec_valid,
    output logic              accept,
    output logic              strip_fcs
);
    flt_state_e                      state;
    logic [CNT_W-1:0]                cnt;
    logic [NBYTES-1:0][BYTE_W-1:0]   addr_q;
    logic [AW-1:0]                   addr_now;
    logic                            byte_take;
    logic                            last_byte;
    logic                            is_group;
    logic                            is_bcast;
    logic                            uni_hit;
    logic                            acc_d;

    assign byte_take   = byte_valid && !frame_end && (state != ST_DONE);
    assign last_byte   = (state == ST_ADDR) && (cnt == CNT_W'(NBYTES - 1));
    assign crc_restart = (state == ST_IDLE);
    assign crc_step    = byte_take;

    // Address as seen on the deciding edge: stored bytes plus the live one.
    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            if (CNT_W'(i) == cnt)
                addr_now[i*BYTE_W +: BYTE_W] = byte_data;
            else
                addr_now[i*BYTE_W +: BYTE_W] = addr_q[i];
        end
    end

    assign is_group = addr_now[0];
    assign is_bcast = &addr_now;
    assign uni_hit  = (addr_now == station);
    assign acc_d    = rx_en && (promisc || is_bcast ||
                      (is_group ? (allmulti || hash_hit) : uni_hit));

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (byte_take) begin                 // T_START
                        addr_q[0] <= byte_data;
                        cnt       <= CNT_W'(1);
                        state     <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (frame_end) begin                 // T_ABORT
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else if (byte_take) begin
                        addr_q[cnt] <= byte_data;
                        if (last_byte) begin             // T_DECIDE
                            cnt   <= '0;
                            state <= ST_DONE;
                        end else begin                   // T_NEXT
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_DONE: begin
                    if (frame_end)                       // T_END
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
            strip_fcs <= 1'b0;
        end else if (byte_take && state == ST_IDLE) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
            strip_fcs <= 1'b0;
        end else if (byte_take && last_byte) begin
            dec_valid <= 1'b1;
            accept    <= acc_d;
            strip_fcs <= strip_cfg;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(NBYTES)); // R2
    AST_DECIDE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(byte_valid)); // R2
    AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && $past(dec_valid) |-> $stable(accept) && $stable(strip_fcs)); // R2
    AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) && !$past(rx_en) |-> !accept); // R3
    AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) && $past(rx_en && promisc) |-> accept); // R4
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADDR && frame_end |=> !dec_valid); // R10
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        promisc,
    input  logic        allmulti,
    input  logic        strip_crc,
    input  logic [15:0] sta_w0,
    input  logic [15:0] sta_w1,
    input  logic [15:0] sta_w2,
    input  logic [15:0] hash_w0,
    input  logic [15:0] hash_w1,
    input  logic [15:0] hash_w2,
    input  logic [15:0] hash_w3,
    input  logic        rx_byte_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_frame_end,
    output logic        dec_valid,
    output logic        accept,
    output logic        strip_fcs
);
    logic [ADDR_W-1:0]     station;
    logic [TABLE_BITS-1:0] table_bits;
    logic [HASH_BITS-1:0]  crc_low;
    logic                  hash_hit;
    logic                  crc_restart;
    logic                  crc_step;

    // Earlier byte in each word's low half, so plain concatenation works.
    assign station    = {sta_w2, sta_w1, sta_w0};
    assign table_bits = {hash_w3, hash_w2, hash_w1, hash_w0};

    rxf_crc_serial #(.DW(BYTE_W), .OUT_W(HASH_BITS)) i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .step    (crc_step),
        .din     (rx_byte),
        .crc_low (crc_low)
    );

    rxf_hash_lookup #(.IDX_W(HASH_BITS)) i_hash (
        .crc_low    (crc_low),
        .table_bits (table_bits),
        .hit        (hash_hit)
    );

    rxf_ctrl #(.NBYTES(ADDR_BYTES)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (rx_byte_valid),
        .byte_data   (rx_byte),
        .frame_end   (rx_frame_end),
        .rx_en       (rx_en),
        .promisc     (promisc),
        .allmulti    (allmulti),
        .strip_cfg   (strip_crc),
        .station     (station),
        .hash_hit    (hash_hit),
        .crc_restart (crc_restart),
        .crc_step    (crc_step),
        .dec_valid   (dec_valid),
        .accept      (accept),
        .strip_fcs   (strip_fcs)
    );
endmodule

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, promisc = 1'b0, allmulti = 1'b0, strip_crc = 1'b0;
    logic [15:0] sta_w0 = '0, sta_w1 = '0, sta_w2 = '0;
    logic [15:0] hash_w0 = '0, hash_w1 = '0, hash_w2 = '0, hash_w3 = '0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_frame_end = 1'b0;
    logic        dec_valid, accept, strip_fcs;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            if (r[0] ^ a[k]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic int ref_idx(input logic [47:0] a);
        logic [31:0] r = ref_crc(a);
        int v = 0;
        for (int k = 0; k < 6; k++) v = (v << 1) | int'(r[k]);
        return v;
    endfunction

    function automatic bit ref_accept(input logic [47:0] a);
        logic [63:0] tbl = {hash_w3, hash_w2, hash_w1, hash_w0};
        logic [47:0] sta = {sta_w2, sta_w1, sta_w0};
        if (!rx_en) return 0;
        if (promisc || a == 48'hFFFF_FFFF_FFFF) return 1;
        if (a[0]) return allmulti || tbl[ref_idx(a)];
        return a == sta;
    endfunction

    function automatic void set_table(input logic [63:0] t);
        {hash_w3, hash_w2, hash_w1, hash_w0} = t;
    endfunction

    task automatic put_byte(input logic [7:0] b);
        rx_byte_valid = 1'b1;
        rx_byte = b;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    task automatic end_frame();
        rx_frame_end = 1'b1;
        @(negedge clk);
        rx_frame_end = 1'b0;
    endtask

    // Sends 6 bytes; returns at the negedge after the deciding edge.
    task automatic send_check(input logic [47:0] a, input string tag);
        bit e = ref_accept(a);
        bit s = strip_crc;
        for (int i = 0; i < 6; i++) put_byte(a[8*i +: 8]);
        chk(dec_valid === 1'b1, {tag, " valid"}, dec_valid, 1);
        chk(accept === e, tag, accept, e);
        chk(strip_fcs === s, "R9 strip", strip_fcs, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        int unsigned s;
        s = $urandom(32'h5EED);
        {sta_w2, sta_w1, sta_w0} = 48'h5544_3322_1100 & 48'hFFFF_FFFF_FFFE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_valid === 0 && accept === 0 && strip_fcs === 0, "R1 reset",
            {dec_valid, accept, strip_fcs}, 0);

        // R3: disabled receive rejects the station address and broadcast
        rx_en = 0; promisc = 1; allmulti = 1;
        send_check({sta_w2, sta_w1, sta_w0}, "R3 off station"); end_frame();
        send_check(48'hFFFF_FFFF_FFFF, "R3 off bcast"); end_frame();
        promisc = 0; allmulti = 0;

        // R4 promiscuous: foreign unicast
        rx_en = 1; promisc = 1;
        send_check(48'h0102_0304_0506 & 48'hFFFF_FFFF_FFFE, "R4 promisc"); end_frame();
        promisc = 0;

        // R5 broadcast with empty table
        set_table('0);
        send_check(48'hFFFF_FFFF_FFFF, "R5 bcast"); end_frame();

        // R6 exact match and one-bit miss (byte 5 / word 2 high half)
        strip_crc = 1;
        send_check({sta_w2, sta_w1, sta_w0}, "R6 match"); end_frame();
        strip_crc = 0;
        send_check({sta_w2, sta_w1, sta_w0} ^ 48'h8000_0000_0000, "R6 miss"); end_frame();

        // R7 all-multicast with empty table
        allmulti = 1;
        send_check(48'h0000_5E00_0001, "R7 allmulti"); end_frame();
        allmulti = 0;

        // R8 hash hit and miss
        a = 48'h0000_5E00_0001;
        set_table(64'd1 << ref_idx(a));
        send_check(a, "R8 hit"); end_frame();
        chk(accept === 1, "R8 hit expected", accept, 1);
        set_table(~(64'd1 << ref_idx(a)));
        send_check(a, "R8 miss"); end_frame();
        chk(accept === 0, "R8 miss expected", accept, 0);

        // R2 hold: decision, then config changes, extra bytes, frame end
        set_table('0);
        strip_crc = 1;
        send_check({sta_w2, sta_w1, sta_w0}, "R2 decide");
        rx_en = 0; strip_crc = 0;
        put_byte(8'hAA); put_byte(8'h55);
        chk(dec_valid === 1 && accept === 1 && strip_fcs === 1, "R2 hold bytes",
            {dec_valid, accept, strip_fcs}, 3'b111);
        end_frame();
        repeat (2) @(negedge clk);
        chk(dec_valid === 1 && accept === 1, "R2 hold after end", {dec_valid, accept}, 2'b11);
        put_byte(8'h00);
        chk(dec_valid === 0 && accept === 0 && strip_fcs === 0, "R2 cleared on start",
            {dec_valid, accept, strip_fcs}, 0);
        end_frame();
        rx_en = 1;

        // R10 runt then full frame
        put_byte(8'hFF); put_byte(8'hFF); put_byte(8'hFF);
        end_frame();
        chk(dec_valid === 0, "R10 runt no decision", dec_valid, 0);
        repeat (2) @(negedge clk);
        chk(dec_valid === 0, "R10 runt still none", dec_valid, 0);
        send_check({sta_w2, sta_w1, sta_w0}, "R10 restart"); end_frame();

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int kind = int'($urandom_range(0, 4));
            rx_en    = ($urandom_range(0, 7) != 0);
            promisc  = ($urandom_range(0, 5) == 0);
            allmulti = ($urandom_range(0, 4) == 0);
            strip_crc = 1'($urandom);
            set_table({$urandom, $urandom} & {$urandom, $urandom});
            case (kind)
                0: a = {sta_w2, sta_w1, sta_w0};
                1: a = 48'hFFFF_FFFF_FFFF;
                2: a = {16'($urandom), $urandom};
                3: a = {sta_w2, sta_w1, sta_w0} ^ (48'd1 << $urandom_range(1, 47));
                default: a = {16'($urandom), $urandom} | 48'd1;
            endcase
            if (a[0]) send_check(a, "R8 random group");
            else      send_check(a, "R6 random unicast");
            if ($urandom_range(0, 1) == 1) put_byte(8'($urandom));
            end_frame();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule